// File: doc/BRIEF.md
# Floating-Point Result Rounder and Flag Generator

This block is the last stage of a floating-point add/subtract datapath. It receives a result that has already been aligned, summed and brought to normalized (or denormal) form: a sign, a biased exponent field, a significand with its hidden bit, one guard bit and one sticky bit. Alongside these come class indicators from the operand stage: an operand was NaN, an operand was infinity, the alignment overshifted, or the operation was invalid. The block rounds the significand and corrects the exponent when rounding carries out. It then packs an IEEE 754 binary word (double precision with the default parameters) and registers the word together with seven status flags.

Two rounding choices are offered through a one-bit mode input: round to nearest with ties to even, and truncation toward zero. Special classes take priority over the arithmetic path, in this order: invalid first, then NaN, then infinity, then the rounded finite result. A finite result whose exponent climbs to the all-ones code becomes a signed infinity, and the overflow flag is raised.

Top module: `fp_round_flags`

## Requirements
- R1: Every cycle with `in_valid` high is followed, one clock later, by `out_valid` high with the matching word and flags. A cycle with `in_valid` low gives `out_valid` low on the next clock and leaves the word and flags unchanged.
- R2: With `rnd_mode` = 0 (nearest, ties to even), the significand is incremented exactly when the guard bit is 1 and either the sticky bit or the significand LSB is 1.
- R3: With `rnd_mode` = 1 (truncate), the significand is never incremented.
- R4: If the increment carries out of the hidden bit, the significand shifts right by one and the exponent rises by one. A denormal (exponent field 0) whose rounding sets the hidden bit is packed with exponent field 1.
- R5: A finite result whose exponent reaches the all-ones code is packed as infinity with the input sign and a zero fraction, with `flag_overflow` and `flag_inexact` set.
- R6: On a finite result, `flag_inexact` equals guard OR sticky.
- R7: `in_invalid` yields the canonical NaN: sign 0, exponent all ones, and a fraction with only its MSB set. It raises `flag_nan` and `flag_invalid` and no other flag, whatever the other inputs are.
- R8: `in_nan` without `in_invalid` yields the same canonical NaN with only `flag_nan` set.
- R9: `in_inf` without NaN or invalid yields infinity with the input sign and a zero fraction. No flag is raised; in particular overflow is never flagged for infinite operands.
- R10: On a finite result, `flag_zero` is set when both exponent and fraction are 0, and `flag_denorm` is set when the exponent is 0 and the fraction is nonzero.
- R11: `flag_overshift` copies `in_overshift` on finite results and is 0 for NaN and infinity results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input fields are valid this cycle |
| rnd_mode | input | 1 | 0 = nearest ties-to-even, 1 = truncate |
| in_sign | input | 1 | Result sign |
| in_exp | input | EXP_W | Biased exponent field before rounding |
| in_mant | input | FRAC_W+1 | Significand, hidden bit at MSB |
| in_guard | input | 1 | First bit below the LSB |
| in_sticky | input | 1 | OR of all lower discarded bits |
| in_nan | input | 1 | An operand was NaN |
| in_inf | input | 1 | Result is an infinite operand |
| in_overshift | input | 1 | Alignment shift exceeded the significand |
| in_invalid | input | 1 | Invalid operation (opposite infinities) |
| out_valid | output | 1 | Registered result valid |
| out_word | output | 1+EXP_W+FRAC_W | Packed sign, exponent, fraction |
| flag_zero | output | 1 | Result is zero |
| flag_overflow | output | 1 | Finite result overflowed to infinity |
| flag_nan | output | 1 | Result is NaN |
| flag_overshift | output | 1 | Result is the larger operand after overshift |
| flag_denorm | output | 1 | Result is denormal |
| flag_inexact | output | 1 | Rounding discarded nonzero bits |
| flag_invalid | output | 1 | Invalid operation |

## Verification
The bench builds the block with a 4-bit exponent and a 3-bit fraction, so one 8-bit word spans the whole number line. In that configuration every exponent code below all-ones, every significand, every guard/sticky pair, both signs and both modes can be swept in under two thousand vectors. The sweep therefore reaches every ties-to-even tie, every carry out of the hidden bit, every denormal promoted to the smallest normal, and every overflow into infinity. Each special class, and each pairing of special classes, is then applied to check the priority order and flag gating.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  typedef enum logic {
    RND_NEAREST_EVEN = 1'b0,
    RND_TRUNCATE     = 1'b1
  } rnd_mode_e;

  typedef struct packed {
    logic zero;
    logic overflow;
    logic nan;
    logic overshift;
    logic denorm;
    logic inexact;
    logic invalid;
  } fpr_flags_t;

endpackage

// File: rtl/fpr_round.sv
module fpr_round
  import fpr_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  rnd_mode_e          mode,
  input  logic [EXP_W-1:0]   exp_in,
  input  logic [FRAC_W:0]    mant_in,
  input  logic               guard,
  input  logic               sticky,
  output logic [EXP_W:0]     exp_out,
  output logic [FRAC_W-1:0]  frac_out,
  output logic               lost_bits
);

  localparam int SUM_W = FRAC_W + 2;

  logic             bump;
  logic [SUM_W-1:0] sum;
  logic [EXP_W:0]   exp_wide;

  always_comb begin
    bump     = (mode == RND_NEAREST_EVEN) & guard & (sticky | mant_in[0]);
    sum      = {1'b0, mant_in} + {{(SUM_W-1){1'b0}}, bump};
    exp_wide = {1'b0, exp_in};
    if (sum[SUM_W-1]) begin
      frac_out = sum[FRAC_W:1];
      exp_out  = exp_wide + 1'b1;
    end else if ((exp_in == '0) && sum[FRAC_W]) begin
      frac_out = sum[FRAC_W-1:0];
      exp_out  = {{EXP_W{1'b0}}, 1'b1};
    end else begin
      frac_out = sum[FRAC_W-1:0];
      exp_out  = exp_wide;
    end
    lost_bits = guard | sticky;
  end

endmodule

// File: rtl/fpr_pack.sv
module fpr_pack
  import fpr_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                    sign,
  input  logic [EXP_W:0]          exp_r,
  input  logic [FRAC_W-1:0]       frac_r,
  input  logic                    lost_bits,
  input  logic                    cls_nan,
  input  logic                    cls_inf,
  input  logic                    cls_ovsh,
  input  logic                    cls_invalid,
  output logic [EXP_W+FRAC_W:0]   word,
  output fpr_flags_t              flags
);

  localparam logic [EXP_W-1:0]  EXP_ONES = {EXP_W{1'b1}};
  localparam logic [EXP_W:0]    EXP_TOP  = {1'b0, EXP_ONES};
  localparam logic [FRAC_W-1:0] QNAN_FR  = {1'b1, {(FRAC_W-1){1'b0}}};

  always_comb begin
    flags = '0;
    if (cls_invalid) begin
      word          = {1'b0, EXP_ONES, QNAN_FR};
      flags.nan     = 1'b1;
      flags.invalid = 1'b1;
    end else if (cls_nan) begin
      word      = {1'b0, EXP_ONES, QNAN_FR};
      flags.nan = 1'b1;
    end else if (cls_inf) begin
      word = {sign, EXP_ONES, {FRAC_W{1'b0}}};
    end else if (exp_r >= EXP_TOP) begin
      word            = {sign, EXP_ONES, {FRAC_W{1'b0}}};
      flags.overflow  = 1'b1;
      flags.inexact   = 1'b1;
      flags.overshift = cls_ovsh;
    end else begin
      word            = {sign, exp_r[EXP_W-1:0], frac_r};
      flags.zero      = (exp_r == '0) && (frac_r == '0);
      flags.denorm    = (exp_r == '0) && (frac_r != '0);
      flags.inexact   = lost_bits;
      flags.overshift = cls_ovsh;
    end
  end

endmodule

// File: rtl/fp_round_flags.sv
module fp_round_flags
  import fpr_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  rnd_mode,
  input  logic                  in_sign,
  input  logic [EXP_W-1:0]      in_exp,
  input  logic [FRAC_W:0]       in_mant,
  input  logic                  in_guard,
  input  logic                  in_sticky,
  input  logic                  in_nan,
  input  logic                  in_inf,
  input  logic                  in_overshift,
  input  logic                  in_invalid,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] out_word,
  output logic                  flag_zero,
  output logic                  flag_overflow,
  output logic                  flag_nan,
  output logic                  flag_overshift,
  output logic                  flag_denorm,
  output logic                  flag_inexact,
  output logic                  flag_invalid
);

  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};

  logic [EXP_W:0]      exp_r;
  logic [FRAC_W-1:0]   frac_r;
  logic                lost_bits;
  logic [WORD_W-1:0]   word_c;
  fpr_flags_t          flags_c;
  fpr_flags_t          flags_q;

  fpr_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .mode      (rnd_mode_e'(rnd_mode)),
    .exp_in    (in_exp),
    .mant_in   (in_mant),
    .guard     (in_guard),
    .sticky    (in_sticky),
    .exp_out   (exp_r),
    .frac_out  (frac_r),
    .lost_bits (lost_bits)
  );

  fpr_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
    .sign        (in_sign),
    .exp_r       (exp_r),
    .frac_r      (frac_r),
    .lost_bits   (lost_bits),
    .cls_nan     (in_nan),
    .cls_inf     (in_inf),
    .cls_ovsh    (in_overshift),
    .cls_invalid (in_invalid),
    .word        (word_c),
    .flags       (flags_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      flags_q   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= word_c;
        flags_q  <= flags_c;
      end
    end
  end

  assign flag_zero      = flags_q.zero;
  assign flag_overflow  = flags_q.overflow;
  assign flag_nan       = flags_q.nan;
  assign flag_overshift = flags_q.overshift;
  assign flag_denorm    = flags_q.denorm;
  assign flag_inexact   = flags_q.inexact;
  assign flag_invalid   = flags_q.invalid;

  logic in_finite;
  assign in_finite = !in_nan && !in_inf && !in_invalid;

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(out_word)); // R1
  AST_TRUNC_NO_INC: assert property (@(posedge clk) disable iff (rst)
    in_valid && rnd_mode && in_finite && in_exp != '0 && in_exp != EXP_ONES
    |=> out_word[FRAC_W-1:0] == $past(in_mant[FRAC_W-1:0])); // R3
  AST_OVF_INF: assert property (@(posedge clk) disable iff (rst)
    flag_overflow |-> out_word[WORD_W-2:FRAC_W] == EXP_ONES && out_word[FRAC_W-1:0] == '0); // R5
  AST_EXACT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_finite && !in_guard && !in_sticky && in_exp != EXP_ONES
    |=> !flag_inexact); // R6
  AST_INVALID_NAN: assert property (@(posedge clk) disable iff (rst)
    flag_invalid |-> flag_nan && out_word[WORD_W-2:FRAC_W] == EXP_ONES && out_word[FRAC_W-1:0] != '0); // R7
  AST_INF_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_inf && !in_nan && !in_invalid |=> !flag_overflow); // R9
  AST_ZERO_FORM: assert property (@(posedge clk) disable iff (rst)
    flag_zero |-> out_word[WORD_W-2:0] == '0); // R10
  AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flag_zero, flag_denorm, flag_nan, flag_overflow})); // R10

endmodule

// File: tb/sim_fp_round_flags.sv
`timescale 1ns/1ps
module sim_fp_round_flags;

  localparam int EW = 4;
  localparam int FW = 3;
  localparam int WW = 1 + EW + FW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, rnd_mode = 1'b0, in_sign = 1'b0;
  logic [EW-1:0] in_exp = '0;
  logic [FW:0]   in_mant = '0;
  logic in_guard = 1'b0, in_sticky = 1'b0, in_nan = 1'b0, in_inf = 1'b0;
  logic in_overshift = 1'b0, in_invalid = 1'b0;
  logic out_valid;
  logic [WW-1:0] out_word;
  logic f_zero, f_ovf, f_nan, f_ovsh, f_den, f_inx, f_inv;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fp_round_flags #(.EXP_W(EW), .FRAC_W(FW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .rnd_mode(rnd_mode),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
    .in_guard(in_guard), .in_sticky(in_sticky), .in_nan(in_nan),
    .in_inf(in_inf), .in_overshift(in_overshift), .in_invalid(in_invalid),
    .out_valid(out_valid), .out_word(out_word),
    .flag_zero(f_zero), .flag_overflow(f_ovf), .flag_nan(f_nan),
    .flag_overshift(f_ovsh), .flag_denorm(f_den), .flag_inexact(f_inx),
    .flag_invalid(f_inv)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected {word, zero, ovf, nan, ovsh, den, inx, inv} and requirement tag
  task automatic apply_and_check(input logic md, input logic sg, input int ex, input int mt,
                                 input logic g, input logic st, input logic nan,
                                 input logic inf, input logic ov, input logic inv);
    int s, e;
    logic [WW-1:0] w;
    logic [6:0] fl;
    string tag;
    @(negedge clk);
    rnd_mode = md; in_sign = sg; in_exp = EW'(ex); in_mant = (FW+1)'(mt);
    in_guard = g; in_sticky = st; in_nan = nan; in_inf = inf;
    in_overshift = ov; in_invalid = inv; in_valid = 1'b1;
    fl = '0;
    if (inv) begin
      w = {1'b0, 4'hF, 3'b100}; fl = 7'b0010001; tag = "R7";
    end else if (nan) begin
      w = {1'b0, 4'hF, 3'b100}; fl = 7'b0010000; tag = "R8";
    end else if (inf) begin
      w = {sg, 4'hF, 3'b000}; tag = "R9";
    end else begin
      s = mt; e = ex;
      if (md == 1'b0 && g && (st || (s % 2 == 1))) s = s + 1;
      tag = md ? "R3" : "R2";
      if (s == 16) begin s = 8; e = e + 1; tag = "R4"; end
      else if (e == 0 && s >= 8) begin e = 1; tag = "R4"; end
      if (e >= 15) begin
        w = {sg, 4'hF, 3'b000}; fl = {1'b0, 1'b1, 1'b0, ov, 1'b0, 1'b1, 1'b0}; tag = "R5";
      end else begin
        w = {sg, 4'(e), 3'(s % 8)};
        fl = {(e == 0 && s % 8 == 0), 1'b0, 1'b0, ov, (e == 0 && s % 8 != 0), (g | st), 1'b0};
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 valid", 32'(out_valid), 32'd1);
    chk(tag, 32'(out_word), 32'(w));
    chk("R6 inexact", 32'(f_inx), 32'(fl[1]));
    chk("R10 zero/denorm", 32'({f_zero, f_den}), 32'({fl[6], fl[2]}));
    chk("R11 overshift", 32'(f_ovsh), 32'(fl[3]));
    chk({tag, " flags"}, 32'({f_zero, f_ovf, f_nan, f_ovsh, f_den, f_inx, f_inv}), 32'(fl));
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [WW-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset valid", 32'(out_valid), 32'd0);
    chk("R1 reset word", 32'(out_word), 32'd0);
    chk("R1 reset flags", 32'({f_zero, f_ovf, f_nan, f_ovsh, f_den, f_inx, f_inv}), 32'd0);

    // full sweep of finite inputs
    for (int md = 0; md < 2; md++)
      for (int sg = 0; sg < 2; sg++)
        for (int ex = 0; ex < 15; ex++)
          for (int m = 0; m < 8; m++)
            for (int gs = 0; gs < 4; gs++)
              apply_and_check(md[0], sg[0], ex, (ex == 0) ? m : 8 + m,
                              gs[1], gs[0], 1'b0, 1'b0, (m == 5), 1'b0);

    // special classes and their priorities
    for (int k = 0; k < 8; k++) begin
      apply_and_check(1'b0, k[0], 9, 13, k[1], 1'b1, 1'b0, 1'b1, k[2], 1'b0); // R9
      apply_and_check(1'b0, k[0], 14, 15, 1'b1, 1'b1, 1'b1, k[1], k[2], 1'b0); // R8
      apply_and_check(k[1], k[0], 3, 10, 1'b1, 1'b0, k[2], 1'b1, 1'b1, 1'b1); // R7
    end

    // R1: no valid, state held
    apply_and_check(1'b0, 1'b1, 6, 12, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    held = out_word;
    @(negedge clk);
    in_exp = 4'h2; in_mant = 4'h9; in_invalid = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk("R1 idle valid", 32'(out_valid), 32'd0);
    chk("R1 idle word held", 32'(out_word), 32'(held));
    chk("R1 idle flags held", 32'(f_inv), 32'd0);
    in_invalid = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule